// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor. The distributor offers one candidate interrupt at a time, made up of a valid flag, an ID and an 8-bit priority. The block raises its interrupt request only when signalling is enabled and the candidate's priority value is strictly below a programmable mask.

The processor claims the offered interrupt by reading the acknowledge register. That read returns the interrupt ID and tells the distributor, in the same cycle, that the line has moved from pending to active. If nothing may be signalled, the read returns the spurious ID 1023 instead. When the handler is done, the processor writes the ID to the completion register. This clears the line's active bit and tells the distributor that the line is now inactive.

A 3-bit binary-point register can be read and written so that software can save and restore it. It has no effect on signalling. Reads and writes use separate ports, so a claim and a completion can land in the same cycle.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, irq is low, the control, mask and binary-point registers read 0, and no line is active.
- R2: irq is high exactly when control bit 0 is 1, cand_valid is 1, cand_id is below NUM_IRQ (default 64) and cand_prio is numerically less than the mask; equal priority does not signal.
- R3: A read at address 3 while irq is high returns cand_id in bits 9:0 with all upper bits 0. In the same cycle it pulses claim_valid with claim_id equal to that ID.
- R4: A read at address 3 while irq is low returns 1023 and leaves claim_valid low.
- R5: A claimed ID becomes active. A later write of that ID to address 4 pulses retire_valid with retire_id equal to the ID during the write cycle.
- R6: A write to address 4 whose ID (bits 9:0) is not active, or is at or above NUM_IRQ, is ignored: retire_valid stays low and no active bit changes.
- R7: After a retire, the line is inactive, and a second write of the same ID to address 4 is ignored.
- R8: Address 0 holds the enable in bit 0, address 1 holds the mask in bits 7:0, and address 2 holds the binary point in bits 2:0. Each reads back what was written, with all other bits 0.
- R9: A claim read and a completion write of a different active ID in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority (lower value is more urgent) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, valid in the strobe cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| irq | output | 1 | Interrupt request to the processor |
| claim_valid | output | 1 | Pending-to-active notification |
| claim_id | output | 10 | ID that became active |
| retire_valid | output | 1 | Active-to-inactive notification |
| retire_id | output | 10 | ID that became inactive |

## Verification
The acknowledge read and the completion write can fall in the same cycle, because they use separate ports. The bench first claims one line. It then makes a second candidate visible, and in a single cycle it reads the acknowledge register and writes the first ID to the completion register. The result is judged by the claim and retire pulses and IDs seen in that cycle. After that, the second line must still retire exactly once and the first must not retire again, which shows that neither update overwrote the other's active bit.

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface #(
  parameter int NUM_IRQ = 64,
  parameter int ID_W    = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cand_valid,
  input  logic [ID_W-1:0] cand_id,
  input  logic [7:0]      cand_prio,
  input  logic            rd_en,
  input  logic [2:0]      rd_addr,
  output logic [31:0]     rd_data,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [31:0]     wr_data,
  output logic            irq,
  output logic            claim_valid,
  output logic [ID_W-1:0] claim_id,
  output logic            retire_valid,
  output logic [ID_W-1:0] retire_id
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [2:0] A_CTRL = 3'd0, A_MASK = 3'd1, A_BP = 3'd2, A_ACK = 3'd3, A_DONE = 3'd4;
  localparam logic [ID_W-1:0] SPURIOUS = ID_W'(1023);
  localparam logic [ID_W-1:0] LIMIT    = ID_W'(NUM_IRQ);

  logic               en_q;
  logic [7:0]         mask_q;
  logic [2:0]         bp_q;
  logic [NUM_IRQ-1:0] act_q;
  logic               ack_rd, done_wr;
  logic [ID_W-1:0]    done_id;
  logic               unused_bits;

  assign unused_bits = ^wr_data[31:ID_W];
  assign done_id     = wr_data[ID_W-1:0];
  assign irq         = en_q && cand_valid && (cand_id < LIMIT) && (cand_prio < mask_q);
  assign ack_rd      = rd_en && (rd_addr == A_ACK);
  assign done_wr     = wr_en && (wr_addr == A_DONE);

  assign claim_valid  = ack_rd && irq;
  assign claim_id     = cand_id;
  assign retire_valid = done_wr && (done_id < LIMIT) && act_q[done_id[IDX_W-1:0]];
  assign retire_id    = done_id;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[0]       = en_q;
      A_MASK: rd_data[7:0]     = mask_q;
      A_BP:   rd_data[2:0]     = bp_q;
      A_ACK:  rd_data[ID_W-1:0] = irq ? cand_id : SPURIOUS;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      bp_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: en_q   <= wr_data[0];
        A_MASK: mask_q <= wr_data[7:0];
        A_BP:   bp_q   <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else begin
      if (retire_valid) act_q[done_id[IDX_W-1:0]] <= 1'b0;
      if (claim_valid)  act_q[cand_id[IDX_W-1:0]] <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !irq && act_q == '0); // R1
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> !irq && !claim_valid); // R2
  AST_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !claim_valid) |-> rd_data == 32'd1023); // R4
  AST_CLAIM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    claim_valid |=> act_q[$past(cand_id[IDX_W-1:0])]); // R5
  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !(claim_valid && cand_id == done_id)) |=> !act_q[$past(done_id[IDX_W-1:0])]); // R7
  AST_NOTIFY_IDS: assert property (@(posedge clk) disable iff (!rst_n)
    claim_valid |-> rd_data[ID_W-1:0] == claim_id && claim_id < LIMIT); // R3
endmodule

// File: tb/test_cpu_irq_iface.sv
module test_cpu_irq_iface;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  rd_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq, claim_valid, retire_valid;
  logic [9:0]  claim_id, retire_id;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  cpu_irq_iface i_cpu_irq_iface (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic offer(logic v, logic [9:0] id, logic [7:0] p);
    @(negedge clk); cand_valid = v; cand_id = id; cand_prio = p;
  endtask

  task automatic claim(string req, logic [9:0] exp_id, logic exp_claim);
    @(negedge clk); rd_en = 1; rd_addr = 3'd3; #1;
    check({req, " ack data"}, rd_data, {22'd0, exp_id});
    check({req, " claim_valid"}, {31'd0, claim_valid}, {31'd0, exp_claim});
    if (exp_claim) check({req, " claim_id"}, {22'd0, claim_id}, {22'd0, exp_id});
    @(negedge clk); rd_en = 0;
  endtask

  task automatic eoi(string req, logic [9:0] id, logic exp_ret);
    @(negedge clk); wr_en = 1; wr_addr = 3'd4; wr_data = {22'd0, id}; #1;
    check({req, " retire_valid"}, {31'd0, retire_valid}, {31'd0, exp_ret});
    if (exp_ret) check({req, " retire_id"}, {22'd0, retire_id}, {22'd0, id});
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1 check("R1 irq", {31'd0, irq}, 0);
    rd(3'd0, d); check("R1 ctrl", d, 0);
    rd(3'd1, d); check("R1 mask", d, 0);
    rd(3'd2, d); check("R1 bp", d, 0);
    for (int i = 32; i < 36; i++) eoi("R1 none active", 10'(i), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); check("R8 ctrl", d, 1);
    wr(3'd1, 32'h1234_56F0); rd(3'd1, d); check("R8 mask", d, 32'hF0);
    wr(3'd2, 32'hFFFF_FFFD); rd(3'd2, d); check("R8 bp", d, 5);
  endtask

  task automatic t_mask();
    offer(1, 10'd40, 8'hF0); #1 check("R2 equal prio", {31'd0, irq}, 0);
    claim("R4 equal prio", 10'd1023, 0);
    offer(1, 10'd40, 8'hEF); #1 check("R2 below mask", {31'd0, irq}, 1);
    wr(3'd0, 0); #1 check("R2 disabled", {31'd0, irq}, 0);
    claim("R4 disabled", 10'd1023, 0);
    wr(3'd0, 1); offer(0, 10'd40, 8'h10); #1 check("R2 no valid", {31'd0, irq}, 0);
    offer(1, 10'd100, 8'h10); #1 check("R2 id range", {31'd0, irq}, 0);
    claim("R4 id range", 10'd1023, 0);
  endtask

  task automatic t_claim_retire();
    offer(1, 10'd33, 8'hA0);
    eoi("R6 not active", 10'd33, 0);
    claim("R3 claim", 10'd33, 1);
    offer(0, 10'd0, 8'h0);
    eoi("R6 other id", 10'd34, 0);
    eoi("R6 out of range", 10'd97, 0);
    eoi("R5 retire", 10'd33, 1);
    eoi("R7 second eoi", 10'd33, 0);
  endtask

  task automatic t_overlap();
    offer(1, 10'd5, 8'h20); claim("R9 first claim", 10'd5, 1);
    offer(1, 10'd50, 8'h30);
    @(negedge clk);
    rd_en = 1; rd_addr = 3'd3; wr_en = 1; wr_addr = 3'd4; wr_data = 32'd5; #1;
    check("R9 ack data", rd_data, 32'd50);
    check("R9 claim", {31'd0, claim_valid}, 1);
    check("R9 retire", {31'd0, retire_valid}, 1);
    check("R9 retire id", {22'd0, retire_id}, 5);
    @(negedge clk); rd_en = 0; wr_en = 0;
    offer(0, 10'd0, 8'h0);
    eoi("R9 first gone", 10'd5, 0);
    eoi("R9 second active", 10'd50, 1);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1 t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_regs();
    t_mask();
    t_claim_retire();
    t_overlap();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule